// File: doc/BRIEF.md
# Clock Buffer Power-Up Sequencer

This block decides when the outputs of a differential clock buffer may be turned on after power is applied. It watches four digital flags that other logic produces: supply good, reference clock present, an active-low power-down request and PLL lock. It walks through four phases: off, a timed settling delay, a wait for the reference clock and power-down release, and run. The output-enable it produces goes to the output gating logic.

The flags are treated as asynchronous. Each one passes through a chain of synchronizer flops before the phase logic uses it. The settling delay is counted on the block clock, which runs freely. Its length comes from two parameters: the timer clock frequency and the delay in nanoseconds. A power-down request in run mode drops the block back to the wait phase and not to off, so a wake-up does not repeat the settling delay. Loss of supply good in any phase returns to off.

Top module: `clkbuf_pwrup_seq`

## Requirements
- R1: While reset is low, and on the first edge after it, `seq_phase` reads 0 (off) and `outputs_en` is 0. The phase codes are 0 off, 1 settle, 2 wait and 3 run.
- R2: Every input flag passes through SYNC_STAGES flops, and these flops reset to 0. The off phase moves to settle on the edge where the synchronized supply flag is first seen high. Otherwise it stays in off.
- R3: The settle phase lasts exactly SETTLE_TICKS clock cycles, then moves to wait. SETTLE_TICKS = TIMER_HZ * SETTLE_NS / 1e9.
- R4: The wait phase holds, with `outputs_en` low, while any of the synchronized reference-clock, power-down-release or lock flags is low.
- R5: The wait phase moves to run, and `outputs_en` rises, only when supply, reference clock, power-down release (`pd_n` high) and lock are all high after synchronization. `outputs_en` is high exactly in the run phase.
- R6: In the run phase, `pd_n` low (or loss of reference clock or lock) returns the block to wait, never to settle or off while supply stays good. `outputs_en` falls on that same edge.
- R7: A synchronized low supply flag forces the off phase from any phase and clears the settle count. A settle that is cut short restarts at full length.
- R8: When every other flag is already high, `outputs_en` rises on the (SYNC_STAGES + SETTLE_TICKS + 2)-th clock edge after `supply_ok` rises. With the defaults this is within 1 ms of timer time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Supply above threshold (asynchronous) |
| refclk_present | input | 1 | Valid reference clock detected (asynchronous) |
| pd_n | input | 1 | Active-low power-down request (asynchronous) |
| pll_locked | input | 1 | PLL lock indication (asynchronous) |
| outputs_en | output | 1 | Permission for the output gating to drive clocks |
| seq_phase | output | 2 | Current phase: 0 off, 1 settle, 2 wait, 3 run |

## Verification
The bench goes after the exact settle length. A counter that is off by one would raise the enable one cycle early or late, and the phase comparison would catch it on that cycle. It drops supply in the middle of a settle and then raises it again. A design that kept the partial count would reach wait too soon. It pulses power-down during run. A design that fell back to off or settle would add a full delay before the enable returned. It also holds lock low while the clock and power-down release are present, which catches a design that enables on clock and power-down alone.

// File: rtl/pwrup_seq_pkg.sv
// Shared types for the clock buffer power-up sequencer.
// Assumes: the phase encoding is visible at the top ports, so the codes are fixed.
package pwrup_seq_pkg;

    typedef enum logic [1:0] {
        PH_OFF    = 2'd0,
        PH_SETTLE = 2'd1,
        PH_WAIT   = 2'd2,
        PH_RUN    = 2'd3
    } phase_t;

    // Bit positions of the flags inside the synchronized bundle
    localparam int unsigned FLG_SUPPLY = 3;
    localparam int unsigned FLG_REFCLK = 2;
    localparam int unsigned FLG_PDREL  = 1;
    localparam int unsigned FLG_LOCK   = 0;
    localparam int unsigned FLG_COUNT  = 4;

endpackage

// File: rtl/pwrup_flag_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous level flags.
// Assumes: the flags are slow levels, so no bus coherence is needed; all stages reset to 0.
module pwrup_flag_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage captures the raw flags
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_in;
                end
            end else begin : g_next
                // Later stages shift toward the output
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= '0;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/pwrup_settle_timer.sv
// Settling delay counter. It counts while enabled and returns to zero whenever it is not.
// Assumes: LIMIT >= 2; done is high during the last cycle of the delay.
module pwrup_settle_timer #(
    parameter int unsigned LIMIT = 26000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam int unsigned CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count while run is high and clear otherwise, so every delay starts from zero
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign done = run && (cnt_q == LAST);

endmodule

// File: rtl/pwrup_phase_fsm.sv
// Phase controller: off -> settle -> wait -> run. Power-down in run falls back to wait;
// loss of supply in any phase returns to off.
// Assumes: all flags are already synchronized to clk.
module pwrup_phase_fsm
    import pwrup_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [FLG_COUNT-1:0] flags,
    input  logic                 settle_done,
    output logic                 settle_run,
    output phase_t               phase,
    output logic                 enable
);

    phase_t phase_q, phase_d;
    logic   enable_q;
    logic   ready;

    assign ready = flags[FLG_REFCLK] && flags[FLG_PDREL] && flags[FLG_LOCK];

    // Next-phase selection
    always_comb begin
        phase_d = phase_q;
        if (!flags[FLG_SUPPLY]) begin
            phase_d = PH_OFF;
        end else begin
            unique case (phase_q)
                PH_OFF:    phase_d = PH_SETTLE;
                PH_SETTLE: if (settle_done) phase_d = PH_WAIT;
                PH_WAIT:   if (ready) phase_d = PH_RUN;
                PH_RUN:    if (!ready) phase_d = PH_WAIT;
                default:   phase_d = PH_OFF;
            endcase
        end
    end

    // Phase and enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_OFF;
            enable_q <= 1'b0;
        end else begin
            phase_q  <= phase_d;
            enable_q <= (phase_d == PH_RUN);
        end
    end

    assign settle_run = (phase_q == PH_SETTLE) && flags[FLG_SUPPLY];
    assign phase      = phase_q;
    assign enable     = enable_q;

endmodule

// File: rtl/clkbuf_pwrup_seq.sv
// Top of the clock buffer power-up sequencer. It synchronizes the four status flags,
// times the settling delay and produces the output enable.
// Assumes: clk is the free-running timer clock at TIMER_HZ.
module clkbuf_pwrup_seq
    import pwrup_seq_pkg::*;
#(
    parameter int unsigned TIMER_HZ    = 100_000_000,
    parameter int unsigned SETTLE_NS   = 260_000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       refclk_present,
    input  logic       pd_n,
    input  logic       pll_locked,
    output logic       outputs_en,
    output logic [1:0] seq_phase
);

    localparam longint unsigned SETTLE_PROD = longint'(TIMER_HZ) * longint'(SETTLE_NS);
    localparam int unsigned SETTLE_TICKS = int'(SETTLE_PROD / 64'd1_000_000_000);
    localparam int unsigned MS_CYCLES    = TIMER_HZ / 1000;

    logic [FLG_COUNT-1:0] raw_flags, sync_flags;
    logic                 settle_run, settle_done;
    phase_t               phase;

    assign raw_flags = {supply_ok, refclk_present, pd_n, pll_locked};

    pwrup_flag_sync #(
        .WIDTH  (FLG_COUNT),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_flags),
        .sync_out (sync_flags)
    );

    pwrup_settle_timer #(
        .LIMIT (SETTLE_TICKS)
    ) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (settle_run),
        .done  (settle_done)
    );

    pwrup_phase_fsm i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .flags       (sync_flags),
        .settle_done (settle_done),
        .settle_run  (settle_run),
        .phase       (phase),
        .enable      (outputs_en)
    );

    assign seq_phase = phase;

endmodule

// File: rtl/pwrup_seq_checker.sv
// Property checker for the power-up sequencer, attached to every instance by bind.
// Assumes: the phase codes from the port table (0 off, 1 settle, 2 wait, 3 run).
module pwrup_seq_checker #(
    parameter int unsigned SETTLE_TICKS = 2,
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned MS_CYCLES    = 100000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       outputs_en,
    input logic [1:0] seq_phase
);

    int unsigned settle_seen;

    // Count the cycles spent in the settle phase
    always_ff @(posedge clk) begin
        if (!rst_n || seq_phase != 2'd1) settle_seen <= 0;
        else                             settle_seen <= settle_seen + 1;
    end

    // R8: the worst-case power-on latency fits within 1 ms
    initial assert_latency_budget_R8: assert (SYNC_STAGES + SETTLE_TICKS + 2 <= MS_CYCLES);

    // R1: reset forces the off phase with the enable low
    assert_reset_off_R1: assert property (@(posedge clk)
        !rst_n |=> (seq_phase == 2'd0 && !outputs_en));

    // R2: off moves only to settle
    assert_off_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_phase == 2'd0) |=> (seq_phase == 2'd0 || seq_phase == 2'd1));

    // R3: the settle phase lasts exactly SETTLE_TICKS cycles before wait
    assert_settle_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_phase == 2'd1) |=> (seq_phase != 2'd2 || settle_seen == SETTLE_TICKS));

    // R5: the enable rises only out of the wait phase
    assert_enable_from_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(outputs_en) |-> ($past(seq_phase) == 2'd2 && seq_phase == 2'd3));

    // R6: run never falls back into settle
    assert_run_no_settle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_phase == 2'd3) |=> (seq_phase != 2'd1));

endmodule

bind clkbuf_pwrup_seq pwrup_seq_checker #(
    .SETTLE_TICKS (SETTLE_TICKS),
    .SYNC_STAGES  (SYNC_STAGES),
    .MS_CYCLES    (MS_CYCLES)
) i_pwrup_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .outputs_en (outputs_en),
    .seq_phase  (seq_phase)
);

// File: tb/test_clkbuf_pwrup_seq.sv
// Bench for the power-up sequencer: a behavioural reference model is compared on every clock,
// and directed checks cover settle length, fallback paths and power-on latency.
module test_clkbuf_pwrup_seq;

    localparam int unsigned TIMER_HZ = 100_000_000;
    localparam int unsigned SET_NS   = 2000;
    localparam int unsigned SYNC     = 2;
    localparam int TICKS = int'((longint'(TIMER_HZ) * SET_NS) / 1_000_000_000);
    localparam int MS    = TIMER_HZ / 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_ok = 1'b0, refclk_present = 1'b0, pd_n = 1'b0, pll_locked = 1'b0;
    logic       outputs_en;
    logic [1:0] seq_phase;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done_flag = 0;

    clkbuf_pwrup_seq #(
        .TIMER_HZ    (TIMER_HZ),
        .SETTLE_NS   (SET_NS),
        .SYNC_STAGES (SYNC)
    ) i_clkbuf_pwrup_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .supply_ok      (supply_ok),
        .refclk_present (refclk_present),
        .pd_n           (pd_n),
        .pll_locked     (pll_locked),
        .outputs_en     (outputs_en),
        .seq_phase      (seq_phase)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Reference model: flags seen after a delay line, phase kept as an integer
    int        m_phase = 0;
    int        m_count = 0;
    bit [3:0]  hist[$];

    always @(posedge clk) begin
        bit [3:0] seen;
        cycles++;
        if (!rst_n) begin
            m_phase = 0;
            m_count = 0;
            hist.delete();
            for (int i = 0; i < SYNC; i++) hist.push_back(4'b0);
        end else begin
            seen = hist.pop_front();
            hist.push_back({supply_ok, refclk_present, pd_n, pll_locked});
            if (!seen[3]) begin
                m_phase = 0;
                m_count = 0;
            end else if (m_phase == 0) begin
                m_phase = 1;
                m_count = 0;
            end else if (m_phase == 1) begin
                m_count++;
                if (m_count == TICKS) begin
                    m_phase = 2;
                    m_count = 0;
                end
            end else if (m_phase == 2) begin
                if (seen[2:0] == 3'b111) m_phase = 3;
            end else begin
                if (seen[2:0] != 3'b111) m_phase = 2;
            end
        end
    end

    // Compare against the model between edges; tag by the phase the model is in
    always @(negedge clk) begin
        string tag;
        case (m_phase)
            0: tag = "R2/R7 off";
            1: tag = "R3 settle";
            2: tag = "R4 wait";
            default: tag = "R5 run";
        endcase
        check(int'(seq_phase) == m_phase, {tag, " phase"}, int'(seq_phase), m_phase);
        check(outputs_en == (m_phase == 3), {tag, " enable"}, int'(outputs_en), int'(m_phase == 3));
    end

    // Watchdog
    always @(posedge clk) begin
        if (cycles > 150000) begin
            check(1'b0, "watchdog", cycles, 150000);
            finish_run();
        end
    end

    // Count edges from a supply rise until seq_phase reaches target
    task automatic measure(input int target, output int n);
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (int'(seq_phase) != target && n < 4 * TICKS);
    endtask

    initial begin
        int n;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(seq_phase == 2'd0 && !outputs_en, "R1 reset", int'(seq_phase), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(seq_phase == 2'd0, "R1 first edge after reset", int'(seq_phase), 0);

        // R2/R3: supply alone, measure entry into wait
        supply_ok = 1'b1;
        measure(2, n);
        check(n == SYNC + TICKS + 1, "R3 settle length to wait", n, SYNC + TICKS + 1);

        // R4: clock and power-down release present, lock missing
        refclk_present = 1'b1;
        pd_n = 1'b1;
        repeat (20) @(negedge clk);
        check(seq_phase == 2'd2 && !outputs_en, "R4 hold without lock", int'(seq_phase), 2);
        // R5: lock arrives
        pll_locked = 1'b1;
        repeat (SYNC + 1) @(negedge clk);
        check(seq_phase == 2'd3 && outputs_en, "R5 run on lock", int'(outputs_en), 1);

        // R6: power-down returns to wait only
        pd_n = 1'b0;
        repeat (SYNC + 1) @(negedge clk);
        check(seq_phase == 2'd2 && !outputs_en, "R6 power-down to wait", int'(seq_phase), 2);
        repeat (10) @(negedge clk);
        pd_n = 1'b1;
        repeat (SYNC + 1) @(negedge clk);
        check(seq_phase == 2'd3, "R6 wake without settle", int'(seq_phase), 3);

        // R6: reference clock loss
        refclk_present = 1'b0;
        repeat (SYNC + 1) @(negedge clk);
        check(seq_phase == 2'd2, "R6 clock loss to wait", int'(seq_phase), 2);
        refclk_present = 1'b1;
        repeat (SYNC + 1) @(negedge clk);
        check(seq_phase == 2'd3, "R5 run after clock return", int'(seq_phase), 3);

        // R7: supply loss in run
        supply_ok = 1'b0;
        repeat (SYNC + 1) @(negedge clk);
        check(seq_phase == 2'd0 && !outputs_en, "R7 supply loss in run", int'(seq_phase), 0);

        // R7: supply cut mid-settle, then full restart
        supply_ok = 1'b1;
        repeat (TICKS / 2) @(negedge clk);
        check(seq_phase == 2'd1, "R3 mid settle", int'(seq_phase), 1);
        supply_ok = 1'b0;
        repeat (SYNC + 3) @(negedge clk);
        check(seq_phase == 2'd0, "R7 supply loss in settle", int'(seq_phase), 0);
        supply_ok = 1'b1;
        measure(3, n);
        check(n == SYNC + TICKS + 2, "R7 full settle after restart", n, SYNC + TICKS + 2);

        // R8: all flags ready before the supply rises
        supply_ok = 1'b0;
        repeat (SYNC + 3) @(negedge clk);
        supply_ok = 1'b1;
        measure(3, n);
        check(n == SYNC + TICKS + 2, "R8 power-on latency", n, SYNC + TICKS + 2);
        check(n <= MS, "R8 within 1 ms", n, MS);
        check(outputs_en == 1'b1, "R8 enable high", int'(outputs_en), 1);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule